// File: doc/BRIEF.md
# Configurable Register-Mapped GPIO Controller

This block is a general-purpose I/O peripheral with between 8 and 64 lines that sits behind a small register bus. It keeps an output latch and a per-line direction state, samples the pad levels through a two-stage synchronizer, and drives the output value and output enable of every pad. Parameters select which registers exist, so one piece of RTL covers several register layouts:

- Output style: a writable level register only; a write-one set register paired with a write-one clear register; or a single set register that holds the whole output word.
- Direction style: no direction register; an output-direction register; an input-direction register; or both direction registers, kept as complements of one shared state.
- Line-to-bit mapping: optionally mirrored, so that line n sits at register bit WIDTH-1-n.

The bus has no flow control. A write takes effect at the clock edge where `bus_wr` is high. A read is captured at the clock edge where `bus_rd` is high, and `bus_rdata` then holds that value until the next read. The block never stalls, so there is no back-pressure rule to follow. Register addresses are 0 (level), 1 (set), 2 (clear), 3 (output direction) and 4 (input direction). Addresses 5 to 7 are always absent.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset the output latch is all zeros and every line is an input: `pad_oe` is 0 whenever any direction register exists. The input-direction register, where present, reads all ones.
- R2: A read of address 0 returns the level of every line (1 = high), taken after two synchronizer flops. A pad change is therefore visible to a read captured at the third rising edge after the change, or at any later edge.
- R3: In set/clear mode, writing address 1 drives high each line whose bit is 1 and leaves lines written with 0 unchanged. Reading address 1 returns the latch.
- R4: In set/clear mode, writing address 2 drives low each line whose bit is 1 and leaves lines written with 0 unchanged. Address 2 reads as zero.
- R5: In set-only mode, writing address 1 loads the whole latch: a 1 drives the line high and a 0 drives it low. Reading address 1 returns the latch.
- R6: In level-only mode, writing address 0 loads the output latch. Reading address 0 still returns the pad levels.
- R7: Where the output-direction register (address 3) exists, a written 1 makes the line an output (`pad_oe` high) and a 0 makes it an input. Reading it returns the direction state.
- R8: Where the input-direction register (address 4) exists, a written 1 makes the line an input and a 0 makes it an output. When both direction registers exist, address 4 always reads as the bitwise complement of address 3.
- R9: With MIRROR=1, line n maps to register bit WIDTH-1-n in every register, for both reads and writes. With MIRROR=0, line n maps to bit n.
- R10: With no direction register, `pad_oe` is all ones at all times, and every line is both driven and sampled.
- R11: A write to an absent register changes neither `pad_out` nor `pad_oe`. A read of an absent register returns zero. Addresses 5 to 7 are absent in every variant, and address 0 is read-only in the set/clear and set-only modes.
- R12: `bus_rdata` changes only at an edge where `bus_rd` is high, and it holds its value while no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | WIDTH | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | WIDTH | Read data, registered |
| pad_in | input | WIDTH | Pad input levels, line order |
| pad_out | output | WIDTH | Output latch, line order |
| pad_oe | output | WIDTH | Output enable per line, line order |

## Verification
A corrupted output latch appears on `pad_out` at the edge after the write that disturbed it, and in a read of the set register one cycle after that read. A wrong direction state appears on `pad_oe` at once. Through the loopback it also changes the level register, three edges later. A mapping fault shows up as a reversed bit pattern the first time a line that is not symmetric in the mapping is written. A corrupted synchronizer stage shows up in any level read made after the pins have settled.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
  // Output-side register layouts.
  localparam int OUTM_LEVEL   = 0;  // level register is writable and loads the latch
  localparam int OUTM_SETCLR  = 1;  // write-one set and write-one clear
  localparam int OUTM_SETONLY = 2;  // one set register holds the full word

  // Direction register layouts.
  localparam int DIRM_NONE = 0;
  localparam int DIRM_OUT  = 1;
  localparam int DIRM_IN   = 2;
  localparam int DIRM_BOTH = 3;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RG_LEVEL = 3'd0,
    RG_SET   = 3'd1,
    RG_CLR   = 3'd2,
    RG_DOUT  = 3'd3,
    RG_DIN   = 3'd4
  } reg_sel_e;

  // Reverse the low w bits of a word; bits above w come back as zero.
  function automatic logic [63:0] lane_flip(input logic [63:0] v, input int w);
    logic [63:0] r;
    r = '0;
    for (int i = 0; i < 64; i++) begin
      if (i < w) r[i] = v[w-1-i];
    end
    return r;
  endfunction
endpackage

// File: rtl/gpio_lane_map.sv
module gpio_lane_map #(
  parameter int W      = 16,
  parameter bit MIRROR = 1'b0
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] y
);
  // The mapping is its own inverse, so one instance serves reads and writes.
  generate
    if (MIRROR) begin : g_flip
      for (genvar i = 0; i < W; i++) begin : g_bit
        assign y[i] = a[W-1-i];
      end
    end else begin : g_pass
      assign y = a;
    end
  endgenerate
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
  import gpio_ctrl_pkg::*;
#(
  parameter int W    = 16,
  parameter int MODE = OUTM_SETCLR
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_level,
  input  logic         wr_set,
  input  logic         wr_clr,
  input  logic [W-1:0] wline,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else if (MODE == OUTM_LEVEL) begin
      if (wr_level) q <= wline;
    end else if (MODE == OUTM_SETONLY) begin
      if (wr_set) q <= wline;
    end else begin
      if (wr_set)      q <= q | wline;
      else if (wr_clr) q <= q & ~wline;
    end
  end
endmodule

// File: rtl/gpio_dir_state.sv
module gpio_dir_state
  import gpio_ctrl_pkg::*;
#(
  parameter int W    = 16,
  parameter int MODE = DIRM_BOTH
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_out,
  input  logic         wr_in,
  input  logic [W-1:0] wline,
  output logic [W-1:0] dir,
  output logic [W-1:0] oe
);
  // dir: 1 means output, kept in line order.
  always_ff @(posedge clk) begin
    if (!rst_n)      dir <= '0;
    else if (wr_out) dir <= wline;
    else if (wr_in)  dir <= ~wline;
  end

  generate
    if (MODE == DIRM_NONE) begin : g_bidir
      assign oe = '1;
    end else begin : g_reg
      assign oe = dir;
    end
  endgenerate
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int W        = 16,
  parameter int OUT_MODE = OUTM_SETCLR,
  parameter int DIR_MODE = DIRM_BOTH,
  parameter bit MIRROR   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [W-1:0]      bus_wdata,
  input  logic              bus_rd,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_oe
);
  localparam bit LEVEL_WR = (OUT_MODE == OUTM_LEVEL);
  localparam bit HAS_SET  = (OUT_MODE != OUTM_LEVEL);
  localparam bit HAS_CLR  = (OUT_MODE == OUTM_SETCLR);
  localparam bit HAS_DOUT = (DIR_MODE == DIRM_OUT) || (DIR_MODE == DIRM_BOTH);
  localparam bit HAS_DIN  = (DIR_MODE == DIRM_IN)  || (DIR_MODE == DIRM_BOTH);

  logic [W-1:0] wline, level, level_bits, latch, latch_bits, dir, dir_bits;
  logic [W-1:0] rd_next;
  logic         wr_level, wr_set, wr_clr, wr_dout, wr_din;

  // Bus bits to line order.
  gpio_lane_map #(.W(W), .MIRROR(MIRROR)) u_map_wr (.a(bus_wdata), .y(wline));

  // Line order back to bus bits for every readable state.
  gpio_lane_map #(.W(W), .MIRROR(MIRROR)) u_map_lvl (.a(level), .y(level_bits));
  gpio_lane_map #(.W(W), .MIRROR(MIRROR)) u_map_lat (.a(latch), .y(latch_bits));
  gpio_lane_map #(.W(W), .MIRROR(MIRROR)) u_map_dir (.a(dir),   .y(dir_bits));

  assign wr_level = bus_wr && (bus_addr == RG_LEVEL) && LEVEL_WR;
  assign wr_set   = bus_wr && (bus_addr == RG_SET)   && HAS_SET;
  assign wr_clr   = bus_wr && (bus_addr == RG_CLR)   && HAS_CLR;
  assign wr_dout  = bus_wr && (bus_addr == RG_DOUT)  && HAS_DOUT;
  assign wr_din   = bus_wr && (bus_addr == RG_DIN)   && HAS_DIN;

  gpio_in_sync #(.W(W)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(level)
  );

  gpio_out_latch #(.W(W), .MODE(OUT_MODE)) u_latch (
    .clk(clk), .rst_n(rst_n), .wr_level(wr_level), .wr_set(wr_set),
    .wr_clr(wr_clr), .wline(wline), .q(latch)
  );

  gpio_dir_state #(.W(W), .MODE(DIR_MODE)) u_dir (
    .clk(clk), .rst_n(rst_n), .wr_out(wr_dout), .wr_in(wr_din),
    .wline(wline), .dir(dir), .oe(pad_oe)
  );

  assign pad_out = latch;

  always_comb begin
    rd_next = '0;
    case (bus_addr)
      RG_LEVEL: rd_next = level_bits;
      RG_SET:   if (HAS_SET)  rd_next = latch_bits;
      RG_DOUT:  if (HAS_DOUT) rd_next = dir_bits;
      RG_DIN:   if (HAS_DIN)  rd_next = ~dir_bits;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk
  import gpio_ctrl_pkg::*;
#(
  parameter int W        = 16,
  parameter int OUT_MODE = OUTM_SETCLR,
  parameter int DIR_MODE = DIRM_BOTH,
  parameter bit MIRROR   = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [W-1:0]      bus_wdata,
  input logic              bus_rd,
  input logic [W-1:0]      bus_rdata,
  input logic [W-1:0]      pad_out,
  input logic [W-1:0]      pad_oe
);
  logic [W-1:0] wl;
  logic [63:0]  flipped;

  assign flipped = lane_flip(64'(bus_wdata), W);
  assign wl      = MIRROR ? flipped[W-1:0] : bus_wdata;

  generate
    if (OUT_MODE == OUTM_SETCLR) begin : g_sc
      a_r3_set_drives_high: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd1) |=> ((pad_out & $past(wl)) == $past(wl)));
      a_r4_clear_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd2) |=> ((pad_out & $past(wl)) == '0));
    end
    if (OUT_MODE == OUTM_SETONLY) begin : g_so
      a_r5_set_full_word: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd1) |=> (pad_out == $past(wl)));
    end
    if (OUT_MODE == OUTM_LEVEL) begin : g_lv
      a_r6_level_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd0) |=> (pad_out == $past(wl)));
    end
    if (DIR_MODE == DIRM_OUT || DIR_MODE == DIRM_BOTH) begin : g_do
      a_r7_dirout_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd3) |=> (pad_oe == $past(wl)));
    end
    if (DIR_MODE == DIRM_IN || DIR_MODE == DIRM_BOTH) begin : g_di
      a_r8_dirin_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd4) |=> (pad_oe == ~$past(wl)));
    end
    if (DIR_MODE == DIRM_NONE) begin : g_nd
      a_r10_oe_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe == '1);
    end
  endgenerate

  a_r11_absent_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr > 3'd4) |=> (bus_rdata == '0));
  a_r11_pads_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr || bus_addr > 3'd4) |=> ($stable(pad_out) && $stable(pad_oe)));
  a_r12_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind gpio_ctrl gpio_ctrl_chk #(
  .W(W), .OUT_MODE(OUT_MODE), .DIR_MODE(DIR_MODE), .MIRROR(MIRROR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/test_gpio_ctrl.sv
module test_gpio_ctrl;
  import gpio_ctrl_pkg::*;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] wdata = '0;

  // A: 16 lines, set/clear, both direction registers, mirrored.
  // B: 8 lines, set-only, input-direction register only, straight.
  // C: 8 lines, level register only, no direction register, straight.
  logic [15:0] rdata_a, out_a, oe_a, ext_a = '0, pin_a;
  logic [7:0]  rdata_b, out_b, oe_b, ext_b = '0, pin_b;
  logic [7:0]  rdata_c, out_c, oe_c, ext_c = '0, pin_c;

  assign pin_a = (oe_a & out_a) | (~oe_a & ext_a);
  assign pin_b = (oe_b & out_b) | (~oe_b & ext_b);
  assign pin_c = (oe_c & out_c) | (~oe_c & ext_c);

  gpio_ctrl #(.W(16), .OUT_MODE(OUTM_SETCLR), .DIR_MODE(DIRM_BOTH), .MIRROR(1'b1)) i_gpio_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
    .bus_rd(rd), .bus_rdata(rdata_a), .pad_in(pin_a), .pad_out(out_a), .pad_oe(oe_a));
  gpio_ctrl #(.W(8), .OUT_MODE(OUTM_SETONLY), .DIR_MODE(DIRM_IN), .MIRROR(1'b0)) i_gpio_ctrl_b (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata[7:0]),
    .bus_rd(rd), .bus_rdata(rdata_b), .pad_in(pin_b), .pad_out(out_b), .pad_oe(oe_b));
  gpio_ctrl #(.W(8), .OUT_MODE(OUTM_LEVEL), .DIR_MODE(DIRM_NONE), .MIRROR(1'b0)) i_gpio_ctrl_c (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata[7:0]),
    .bus_rd(rd), .bus_rdata(rdata_c), .pad_in(pin_c), .pad_out(out_c), .pad_oe(oe_c));

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  logic [15:0] lat_a = '0, dir_a = '0;
  logic [7:0]  lat_b = '0, dir_b = '0, lat_c = '0;

  function automatic logic [15:0] mir16(input logic [15:0] v);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = v[15-i];
    return r;
  endfunction

  function automatic logic [15:0] exp_rd_a(input logic [2:0] a);
    logic [15:0] lvl;
    lvl = (dir_a & lat_a) | (~dir_a & ext_a);
    case (a)
      3'd0: return mir16(lvl);
      3'd1: return mir16(lat_a);
      3'd3: return mir16(dir_a);
      3'd4: return ~mir16(dir_a);
      default: return '0;
    endcase
  endfunction

  function automatic logic [7:0] exp_rd_b(input logic [2:0] a);
    case (a)
      3'd0: return (dir_b & lat_b) | (~dir_b & ext_b);
      3'd1: return lat_b;
      3'd4: return ~dir_b;
      default: return '0;
    endcase
  endfunction

  function automatic logic [7:0] exp_rd_c(input logic [2:0] a);
    return (a == 3'd0) ? lat_c : 8'h00;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_pads(input string tag);
    chk({tag, " pad_out A"}, 64'(out_a), 64'(lat_a));
    chk({tag, " pad_oe A"},  64'(oe_a),  64'(dir_a));
    chk({tag, " pad_out B"}, 64'(out_b), 64'(lat_b));
    chk({tag, " pad_oe B"},  64'(oe_b),  64'(dir_b));
    chk({tag, " pad_out C"}, 64'(out_c), 64'(lat_c));
    chk({tag, " R10 pad_oe C"}, 64'(oe_c), 64'hFF);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input logic [2:0] a, input logic [15:0] d, input string tag);
    @(negedge clk);
    addr = a; wr = 1'b1; wdata = d;
    @(negedge clk);
    wr = 1'b0;
    case (a)
      3'd1: begin lat_a = lat_a | mir16(d); lat_b = d[7:0]; end
      3'd2: lat_a = lat_a & ~mir16(d);
      3'd3: dir_a = mir16(d);
      3'd4: begin dir_a = ~mir16(d); dir_b = ~d[7:0]; end
      3'd0: lat_c = d[7:0];
      default: ;
    endcase
    chk_pads(tag);
  endtask

  task automatic do_read(input logic [2:0] a, input string tag);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    chk({tag, " rdata A"}, 64'(rdata_a), 64'(exp_rd_a(a)));
    chk({tag, " rdata B"}, 64'(rdata_b), 64'(exp_rd_b(a)));
    chk({tag, " rdata C"}, 64'(rdata_c), 64'(exp_rd_c(a)));
  endtask

  task automatic sweep(input string tag);
    idle(3);
    for (int a = 0; a < 8; a++) do_read(3'(a), tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] held;
    void'($urandom(32'd20240517));
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk_pads("R1 reset");
    sweep("R1 reset reads R2 R11");

    // R3 R9: set bit 0 of A lands on line 15
    do_write(3'd1, 16'h0001, "R3 R9 set mirrored");
    chk("R9 line15 high", 64'(out_a), 64'h8000);
    do_write(3'd1, 16'h00F0, "R3 set keeps zeros");
    chk("R3 accumulate", 64'(out_a), 64'h8F00);
    do_write(3'd2, 16'h0010, "R4 clear one bit");
    chk("R4 clear", 64'(out_a), 64'h8700);
    // R7 R8 direction
    do_write(3'd3, 16'h0003, "R7 dirout");
    chk("R7 R9 oe mirrored", 64'(oe_a), 64'hC000);
    do_write(3'd4, 16'h00FF, "R8 dirin");
    chk("R8 oe complement", 64'(oe_a), 64'h00FF);
    chk("R8 B dirin oe", 64'(oe_b), 64'h00);
    // R5 set-only full word, R6 level write
    do_write(3'd1, 16'h005A, "R5 set word");
    do_write(3'd1, 16'h000F, "R5 zeros drive low");
    chk("R5 B out", 64'(out_b), 64'h0F);
    do_write(3'd0, 16'h003C, "R6 level write");
    chk("R6 C out", 64'(out_c), 64'h3C);
    // R11 absent registers
    do_write(3'd6, 16'hFFFF, "R11 absent write");
    do_write(3'd3, 16'hFFFF, "R11 B C no dirout");
    sweep("R2 R8 R11 after directed");

    // R12 rdata holds without a read
    do_read(3'd1, "R12 setup");
    held = rdata_a;
    addr = 3'd4;
    idle(3);
    chk("R12 rdata hold", 64'(rdata_a), 64'(held));

    // Random mix
    for (int it = 0; it < 250; it++) begin
      int op;
      op = $urandom % 4;
      if (op == 0) begin
        ext_a = 16'($urandom); ext_b = 8'($urandom); ext_c = 8'($urandom);
      end else begin
        do_write(3'($urandom % 8), 16'($urandom), "R3 R4 R5 R6 R7 R8 random write");
      end
      if ((it % 5) == 4) sweep("R2 R9 random read");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule